// File: doc/BRIEF.md
# Viterbi Traceback Survivor Decoder

This block is the back end of a convolutional-code decoder. Once per trellis step, an add-compare-select array hands it one decision bit for every encoder state, plus the index of the state it considers best at that step. Each decision bit says which of the two possible predecessors won at that state. The block keeps these decision vectors in a circular store and never holds whole survivor paths. From them it recovers the transmitted bit stream by walking backwards through the trellis.

Decoding is block-wise, so an unterminated stream can be handled. The first pass waits until D + N steps have been stored. It then walks back from the latest step for D steps without producing anything, so that the walk reaches the region where all survivors agree. It then walks back N more steps and collects the N bits found there. These bits are put back into time order and sent out oldest first, one per clock, with a valid strobe. After that, another pass runs each time N further steps have been stored.

State convention: when input bit u is applied, state s becomes `{s[S-2:0], u}`, where S = K-1. The decoded bit of a step is therefore the least significant bit of the state reached in that step. The decision bit stored at a state is the most significant bit of its winning predecessor.

Top module: `viterbi_traceback_decoder`

## Requirements
- R1: After a synchronous active-high reset, `bit_valid` is low and no decoded bit is produced until new decision vectors arrive.
- R2: Bit t of the decision vector for step j is the most significant bit of the winning predecessor of state t. The walk back from state t forms the predecessor `{decision, t[S-1:1]}`. The decoded bit for a state is its bit 0.
- R3: No bit is output before D + N decision vectors have been written since reset.
- R4: Each traceback pass outputs exactly N bits, on N consecutive clock cycles.
- R5: Output bits leave in time order. The k-th bit output since reset is the input bit of trellis step k, so the stream is continuous from one pass to the next.
- R6: After the first pass, a new pass runs after every further N vectors. Once L vectors have been written and the block has gone idle, floor((L-D)/N)·N bits have been output.
- R7: Traceback may start at any state named by `dec_end_state`. If all survivors merge within D steps, the output equals the transmitted bits.
- R8: Decision bits of states that lie off the traced path have no effect on the output.
- R9: A reset in the middle of a stream discards all partial progress, and the next output again waits for D + N fresh vectors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_valid | input | 1 | A decision vector is presented this cycle |
| dec_vec | input | 2^(K-1) | One survivor decision bit per state |
| dec_end_state | input | K-1 | Best state at this step; used as the start state for traceback |
| bit_valid | output | 1 | `bit_out` holds a decoded bit |
| bit_out | output | 1 | Decoded bit, oldest first |

## Verification
A corrupted traceback pointer or state register shows up as wrong decoded bits within the same pass. Such bits leave at most D + 2N + 2 cycles after the triggering vector. A fault in the fill counter instead shows up as a first burst that comes too early or too late, or as a missing or extra burst. These are visible in the count of bits per burst and in the total number of bits. A fault in the reversal store flips bit order inside a burst. The bench detects this at the first pattern that is not symmetric within an N-bit block.

// File: rtl/vtb_pkg.sv
package vtb_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_TRACE = 2'd1,
        PH_EMIT  = 2'd2
    } phase_e;

    // Ring must cover one full pass span (D+N) plus one block written meanwhile.
    function automatic int ring_slots(input int depth_d, input int block_n);
        return 1 << $clog2(depth_d + 2 * block_n);
    endfunction

endpackage

// File: rtl/vtb_survivor_ram.sv
module vtb_survivor_ram #(
    parameter int NS = 64,
    parameter int SLOTS = 128,
    parameter int AW = 7,
    parameter int SW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [NS-1:0] wr_vec,
    output logic [AW-1:0] wr_ptr,
    input  logic [AW-1:0] rd_addr,
    input  logic [SW-1:0] rd_sel,
    output logic          rd_bit
);
    logic [NS-1:0] store [SLOTS];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            store[wr_ptr] <= wr_vec;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
        end else if (wr_en) begin
            wr_ptr <= wr_ptr + 1'b1;
        end
    end

    assign rd_bit = store[rd_addr][rd_sel];

endmodule

// File: rtl/vtb_block_sched.sv
module vtb_block_sched #(
    parameter int D = 64,
    parameter int N = 32,
    parameter int AW = 7,
    parameter int SW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_ptr,
    input  logic [SW-1:0] end_state,
    output logic          req,
    output logic [AW-1:0] req_ptr,
    output logic [SW-1:0] req_state
);
    localparam int FW = $clog2(D + N + 1);
    localparam logic [FW-1:0] FIRST_GOAL = FW'(D + N);
    localparam logic [FW-1:0] NEXT_GOAL  = FW'(N);

    logic [FW-1:0] fill;
    logic          primed;
    logic [FW-1:0] goal;

    assign goal = primed ? NEXT_GOAL : FIRST_GOAL;

    always_ff @(posedge clk) begin
        if (rst) begin
            fill      <= '0;
            primed    <= 1'b0;
            req       <= 1'b0;
            req_ptr   <= '0;
            req_state <= '0;
        end else begin
            req <= 1'b0;
            if (wr_en) begin
                if (fill + 1'b1 == goal) begin
                    fill      <= '0;
                    primed    <= 1'b1;
                    req       <= 1'b1;
                    req_ptr   <= wr_ptr;
                    req_state <= end_state;
                end else begin
                    fill <= fill + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/vtb_trace_engine.sv
module vtb_trace_engine
    import vtb_pkg::*;
#(
    parameter int D = 64,
    parameter int N = 32,
    parameter int AW = 7,
    parameter int SW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req,
    input  logic [AW-1:0] req_ptr,
    input  logic [SW-1:0] req_state,
    output logic [AW-1:0] rd_addr,
    output logic [SW-1:0] rd_sel,
    input  logic          rd_bit,
    output logic          bit_valid,
    output logic          bit_out
);
    localparam int IW = $clog2(D + N);
    localparam int OW = (N > 1) ? $clog2(N) : 1;
    localparam logic [IW-1:0] LAST_STEP = IW'(D + N - 1);
    localparam logic [IW-1:0] SKIP_END  = IW'(D);
    localparam logic [OW-1:0] LAST_OUT  = OW'(N - 1);

    phase_e        phase;
    logic          pending;
    logic [AW-1:0] p_ptr;
    logic [SW-1:0] p_state;
    logic [AW-1:0] ptr;
    logic [SW-1:0] st;
    logic [IW-1:0] step;
    logic [OW-1:0] out_idx;
    logic [N-1:0]  rev;
    logic [IW-1:0] slot;

    assign rd_addr = ptr;
    assign rd_sel  = st;
    assign slot    = LAST_STEP - step;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            pending   <= 1'b0;
            p_ptr     <= '0;
            p_state   <= '0;
            ptr       <= '0;
            st        <= '0;
            step      <= '0;
            out_idx   <= '0;
            rev       <= '0;
            bit_valid <= 1'b0;
            bit_out   <= 1'b0;
        end else begin
            bit_valid <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    if (pending) begin
                        pending <= 1'b0;
                        ptr     <= p_ptr;
                        st      <= p_state;
                        step    <= '0;
                        phase   <= PH_TRACE;
                    end
                end
                PH_TRACE: begin
                    if (step >= SKIP_END) begin
                        rev[OW'(slot)] <= st[0];
                    end
                    st  <= {rd_bit, st[SW-1:1]};
                    ptr <= ptr - 1'b1;
                    if (step == LAST_STEP) begin
                        out_idx <= '0;
                        phase   <= PH_EMIT;
                    end else begin
                        step <= step + 1'b1;
                    end
                end
                PH_EMIT: begin
                    bit_valid <= 1'b1;
                    bit_out   <= rev[out_idx];
                    if (out_idx == LAST_OUT) begin
                        phase <= PH_IDLE;
                    end else begin
                        out_idx <= out_idx + 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
            if (req) begin
                pending <= 1'b1;
                p_ptr   <= req_ptr;
                p_state <= req_state;
            end
        end
    end

endmodule

// File: rtl/viterbi_traceback_decoder.sv
module viterbi_traceback_decoder
    import vtb_pkg::*;
#(
    parameter int CONSTR_LEN = 7,
    parameter int DEPTH_D = 64,
    parameter int BLOCK_N = 32
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              dec_valid,
    input  logic [(1 << (CONSTR_LEN-1))-1:0]  dec_vec,
    input  logic [CONSTR_LEN-2:0]             dec_end_state,
    output logic                              bit_valid,
    output logic                              bit_out
);
    localparam int SW    = CONSTR_LEN - 1;
    localparam int NS    = 1 << SW;
    localparam int SLOTS = ring_slots(DEPTH_D, BLOCK_N);
    localparam int AW    = $clog2(SLOTS);

    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_addr;
    logic [SW-1:0] rd_sel;
    logic          rd_bit;
    logic          req;
    logic [AW-1:0] req_ptr;
    logic [SW-1:0] req_state;

    vtb_survivor_ram #(.NS(NS), .SLOTS(SLOTS), .AW(AW), .SW(SW)) ram_i (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (dec_valid),
        .wr_vec (dec_vec),
        .wr_ptr (wr_ptr),
        .rd_addr(rd_addr),
        .rd_sel (rd_sel),
        .rd_bit (rd_bit)
    );

    vtb_block_sched #(.D(DEPTH_D), .N(BLOCK_N), .AW(AW), .SW(SW)) sched_i (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (dec_valid),
        .wr_ptr   (wr_ptr),
        .end_state(dec_end_state),
        .req      (req),
        .req_ptr  (req_ptr),
        .req_state(req_state)
    );

    vtb_trace_engine #(.D(DEPTH_D), .N(BLOCK_N), .AW(AW), .SW(SW)) engine_i (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .req_ptr  (req_ptr),
        .req_state(req_state),
        .rd_addr  (rd_addr),
        .rd_sel   (rd_sel),
        .rd_bit   (rd_bit),
        .bit_valid(bit_valid),
        .bit_out  (bit_out)
    );

endmodule

// File: rtl/vtb_checker.sv
module vtb_checker #(
    parameter int D = 64,
    parameter int N = 32
) (
    input logic clk,
    input logic rst,
    input logic dec_valid,
    input logic bit_valid
);
    logic [31:0] wr_cnt;
    logic [31:0] out_cnt;
    logic [31:0] run;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_cnt  <= '0;
            out_cnt <= '0;
            run     <= '0;
        end else begin
            if (dec_valid) wr_cnt <= wr_cnt + 1;
            if (bit_valid) out_cnt <= out_cnt + 1;
            run <= bit_valid ? run + 1 : '0;
        end
    end

    // R3: silent until D+N vectors are in
    a_r3_no_early_bits: assert property (@(posedge clk) disable iff (rst)
        (wr_cnt < 32'(D + N)) |-> !bit_valid);

    // R4: a burst never exceeds N bits
    a_r4_burst_cap: assert property (@(posedge clk) disable iff (rst)
        bit_valid |-> (run < 32'(N)));

    // R4: a burst that ends has exactly N bits
    a_r4_burst_len: assert property (@(posedge clk) disable iff (rst)
        $fell(bit_valid) |-> (run == 32'(N)));

    // R6: output never runs ahead of settled steps
    a_r6_out_bound: assert property (@(posedge clk) disable iff (rst)
        bit_valid |-> (out_cnt + 32'(D) < wr_cnt));

endmodule

bind viterbi_traceback_decoder vtb_checker #(.D(DEPTH_D), .N(BLOCK_N)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .dec_valid(dec_valid),
    .bit_valid(bit_valid)
);

// File: tb/viterbi_traceback_decoder_tb_top.sv
module viterbi_traceback_decoder_tb_top;
    localparam int K  = 4;
    localparam int S  = K - 1;
    localparam int NS = 1 << S;
    localparam int D  = 6;
    localparam int N  = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          dec_valid = 1'b0;
    logic [NS-1:0] dec_vec = '0;
    logic [S-1:0]  dec_end_state = '0;
    logic          bit_valid;
    logic          bit_out;

    int    checks = 0;
    int    errors = 0;
    int    sent = 0;
    int    out_idx = 0;
    int    run_len = 0;
    bit    seen_first = 1'b0;
    bit    done = 1'b0;
    bit    exp_u [512];
    string cur_tag = "R5";
    logic [15:0] lfsr = 16'hACE1;

    always #10 clk = ~clk;

    viterbi_traceback_decoder #(.CONSTR_LEN(K), .DEPTH_D(D), .BLOCK_N(N)) dut_i (
        .clk          (clk),
        .rst          (rst),
        .dec_valid    (dec_valid),
        .dec_vec      (dec_vec),
        .dec_end_state(dec_end_state),
        .bit_valid    (bit_valid),
        .bit_out      (bit_out)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit next_rand();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return lfsr[0];
    endfunction

    // Monitor: bits in time order, first-bit timing, burst length
    always @(negedge clk) begin
        if (!rst) begin
            if (bit_valid) begin
                if (!seen_first) begin
                    seen_first = 1'b1;
                    check(sent >= D + N, "R3 first bit after D+N vectors", sent, D + N);
                end
                check(bit_out == exp_u[out_idx], cur_tag, int'(bit_out), int'(exp_u[out_idx]));
                out_idx++;
                run_len++;
            end else if (run_len != 0) begin
                check(run_len == N, "R4 burst length", run_len, N);
                run_len = 0;
            end
        end
    end

    // mode 0: true end state, random off-path decisions (R8)
    // mode 1: random end state, every state carries the true decision (R7)
    task automatic run_case(input int mode, input int pattern, input int len, input string tag);
        logic [S-1:0] s_prev;
        logic [S-1:0] s_now;
        bit u;
        @(negedge clk);
        rst = 1'b1;
        dec_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        sent = 0;
        out_idx = 0;
        run_len = 0;
        seen_first = 1'b0;
        cur_tag = tag;
        @(negedge clk);
        check(bit_valid == 1'b0, "R1 idle after reset", int'(bit_valid), 0);
        s_prev = '0;
        for (int j = 0; j < len; j++) begin
            case (pattern)
                0: u = 1'b0;
                1: u = 1'b1;
                2: u = j[0];
                3: u = (j % 3) == 0;
                default: u = next_rand();
            endcase
            exp_u[j] = u;
            s_now = {s_prev[S-2:0], u};
            for (int t = 0; t < NS; t++) begin
                if (mode == 1 || t == int'(s_now)) dec_vec[t] = s_prev[S-1];
                else dec_vec[t] = next_rand();
            end
            if (mode == 1) dec_end_state = {next_rand(), next_rand(), next_rand()};
            else dec_end_state = s_now;
            dec_valid = 1'b1;
            sent++;
            @(negedge clk);
            dec_valid = 1'b0;
            repeat (4) @(negedge clk);
            s_prev = s_now;
        end
        repeat (60) @(negedge clk);
        check(out_idx == ((len >= D) ? ((len - D) / N) * N : 0),
              "R6 total bits emitted", out_idx, (len >= D) ? ((len - D) / N) * N : 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        run_case(0, 0, 22, "R2 R5 zeros");
        run_case(0, 1, 22, "R2 R5 ones");
        run_case(0, 2, 26, "R5 alternating");
        run_case(0, 3, 27, "R5 period3");
        run_case(0, 4, 40, "R8 random off-path");
        run_case(1, 4, 34, "R7 any end state");
        run_case(1, 2, 30, "R7 any end state alt");
        run_case(0, 4, 8,  "R3 short stream");
        run_case(0, 4, 18, "R9 after mid reset");
        run_case(1, 3, 9,  "R9 reset cut");
        run_case(0, 4, 14, "R6 single pass");
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule